// File: doc/BRIEF.md
# Time-Multiplexed Two-Read One-Write RAM Adapter

This block lets a core see one single-port memory array as a memory with two read ports and one write port. The array runs on the fast clock. The core advances at half that rate, under a clock enable that a single divide-by-two phase flip-flop produces. Each core cycle is two fast cycles. The first fast cycle is the A slot, where the array is read at the A address. The second is the B slot, where the array is read at the B address, or written instead if a write is pending.

The core holds its addresses and write request stable for a whole core cycle, and its registers update on the fast edge where `core_ce_o` is high. Read results for the addresses of core cycle k appear on that same enabled edge and hold through core cycle k+1. A write requested in cycle k is parked in a pending register. It is committed in the B slot of cycle k+1, and the B read of that cycle is dropped. A read of A in cycle k+1 at the address being written is served from the pending register, so the core always sees the latest value.

Top module: `twin_read_ram`

## Requirements
- R1: The phase flip-flop resets to the A slot, so `core_ce_o` is 0 during reset and in the first fast cycle after reset. After that it toggles on every fast clock edge: it is 0 in the A slot and 1 in the B slot.
- R2: If `rd_a_addr_i` is held through core cycle k, `rd_a_data_o` shows the word at that address from the enabled edge that ends cycle k.
- R3: If `rd_b_addr_i` is held through core cycle k and no write was requested in cycle k-1, `rd_b_data_o` shows the word at that address from the enabled edge that ends cycle k.
- R4: `rd_a_data_o` and `rd_b_data_o` change only on enabled edges, so each stays constant for a whole core cycle.
- R5: A write with `wr_en_i`=1 in core cycle k stores `wr_data_i` at `wr_addr_i`, and both read ports return the new value from core cycle k+2 onward.
- R6: A read of A in core cycle k+1 at the address written in core cycle k returns the newly written data. If several writes to that address came back to back, it returns the data of the latest one.
- R7: In the core cycle after a write request, the B read is skipped and `rd_b_data_o` keeps its previous value.
- R8: With `wr_en_i`=0, the values on `wr_addr_i` and `wr_data_i` do not change the memory contents.
- R9: During reset both read outputs are 0, and the array starts with all words at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock (array rate) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_ce_o | output | 1 | Core clock enable: high in the B slot |
| rd_a_addr_i | input | $clog2(DEPTH) | Read address for port A |
| rd_a_data_o | output | WIDTH | Registered read data for port A |
| rd_b_addr_i | input | $clog2(DEPTH) | Read address for port B |
| rd_b_data_o | output | WIDTH | Registered read data for port B |
| wr_en_i | input | 1 | Write request for this core cycle |
| wr_addr_i | input | $clog2(DEPTH) | Write address |
| wr_data_i | input | WIDTH | Write data |

## Verification
Read data for core cycle k is due on the enabled edge two fast edges after the inputs are driven. A write of cycle k is due in the array at the end of cycle k+1, and reads see it from cycle k+2 on, or from cycle k+1 through the pending-register forward on port A. The bench drives its inputs on the falling edge at the start of an A slot. It samples at the falling edge inside the B slot to confirm the outputs have not moved yet, then samples again at the falling edge starting the next A slot, where the new results must be present. A reference array in the bench is updated only after the reads of the same cycle are checked, and it remembers whether the previous cycle wrote, so it can predict when port B keeps its previous value.

// File: rtl/twin_read_ram_pkg.sv
package twin_read_ram_pkg;
  typedef enum logic {
    PH_A = 1'b0,
    PH_B = 1'b1
  } phase_e;
endpackage

// File: rtl/twin_read_phase.sv
module twin_read_phase
  import twin_read_ram_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  output phase_e phase_o
);
  phase_e ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_A;
    else         ph_q <= (ph_q == PH_A) ? PH_B : PH_A;
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/twin_read_array.sv
module twin_read_array #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem_q[i] = '0;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/twin_read_sched.sv
module twin_read_sched
  import twin_read_ram_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  phase_e           phase_i,
  input  logic [AW-1:0]    rd_a_addr_i,
  input  logic [AW-1:0]    rd_b_addr_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [AW-1:0]    ram_addr_o,
  output logic             ram_we_o,
  output logic [WIDTH-1:0] ram_wdata_o,
  input  logic [WIDTH-1:0] ram_rdata_i,
  output logic [WIDTH-1:0] rd_a_data_o,
  output logic [WIDTH-1:0] rd_b_data_o
);
  logic             pend_v_q;
  logic [AW-1:0]    pend_addr_q;
  logic [WIDTH-1:0] pend_data_q;
  logic [WIDTH-1:0] a_stage_q, a_out_q, b_out_q;
  logic             fwd_a;

  // B slot is lent to the pending write
  always_comb begin
    ram_addr_o = rd_a_addr_i;
    if (phase_i == PH_B) ram_addr_o = pend_v_q ? pend_addr_q : rd_b_addr_i;
  end
  assign ram_we_o    = (phase_i == PH_B) && pend_v_q;
  assign ram_wdata_o = pend_data_q;
  assign fwd_a       = pend_v_q && (pend_addr_q == rd_a_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q    <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
      a_stage_q   <= '0;
      a_out_q     <= '0;
      b_out_q     <= '0;
    end else if (phase_i == PH_A) begin
      a_stage_q <= fwd_a ? pend_data_q : ram_rdata_i;
    end else begin
      a_out_q <= a_stage_q;
      if (!pend_v_q) b_out_q <= ram_rdata_i;
      pend_v_q    <= wr_en_i;
      pend_addr_q <= wr_addr_i;
      pend_data_q <= wr_data_i;
    end
  end

  assign rd_a_data_o = a_out_q;
  assign rd_b_data_o = b_out_q;
endmodule

// File: rtl/twin_read_ram.sv
module twin_read_ram
  import twin_read_ram_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             core_ce_o,
  input  logic [AW-1:0]    rd_a_addr_i,
  output logic [WIDTH-1:0] rd_a_data_o,
  input  logic [AW-1:0]    rd_b_addr_i,
  output logic [WIDTH-1:0] rd_b_data_o,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i
);
  phase_e           phase;
  logic [AW-1:0]    ram_addr;
  logic             ram_we;
  logic [WIDTH-1:0] ram_wdata, ram_rdata;

  twin_read_phase u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase)
  );

  twin_read_sched #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_sched (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_i     (phase),
    .rd_a_addr_i (rd_a_addr_i),
    .rd_b_addr_i (rd_b_addr_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .ram_addr_o  (ram_addr),
    .ram_we_o    (ram_we),
    .ram_wdata_o (ram_wdata),
    .ram_rdata_i (ram_rdata),
    .rd_a_data_o (rd_a_data_o),
    .rd_b_data_o (rd_b_data_o)
  );

  twin_read_array #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_array (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .addr_i  (ram_addr),
    .wdata_i (ram_wdata),
    .rdata_o (ram_rdata)
  );

  assign core_ce_o = (phase == PH_B);
endmodule

// File: rtl/twin_read_ram_chk.sv
module twin_read_ram_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             core_ce_o,
  input logic             wr_en_i,
  input logic [WIDTH-1:0] rd_a_data_o,
  input logic [WIDTH-1:0] rd_b_data_o
);
  a_r1_ce_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_ce_o |=> core_ce_o);

  a_r1_ce_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_ce_o |=> !core_ce_o);

  a_r4_a_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_ce_o |=> $stable(rd_a_data_o));

  a_r4_b_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_ce_o |=> $stable(rd_b_data_o));

  a_r7_b_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_ce_o && wr_en_i) |-> ##3 $stable(rd_b_data_o));

  a_r9_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> (rd_a_data_o == '0 && rd_b_data_o == '0 && !core_ce_o));
endmodule

bind twin_read_ram twin_read_ram_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .core_ce_o   (core_ce_o),
  .wr_en_i     (wr_en_i),
  .rd_a_data_o (rd_a_data_o),
  .rd_b_data_o (rd_b_data_o)
);

// File: tb/twin_read_ram_tb_top.sv
module twin_read_ram_tb_top;
  localparam int DEPTH = 16;
  localparam int WIDTH = 8;
  localparam int AW = $clog2(DEPTH);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             core_ce_o;
  logic [AW-1:0]    rd_a_addr_i = '0, rd_b_addr_i = '0, wr_addr_i = '0;
  logic [WIDTH-1:0] rd_a_data_o, rd_b_data_o, wr_data_i = '0;
  logic             wr_en_i = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [WIDTH-1:0] model [DEPTH];
  logic [WIDTH-1:0] prev_a = '0, prev_b = '0;
  bit               prev_we = 1'b0;

  always #4 clk_i = ~clk_i;

  twin_read_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .core_ce_o   (core_ce_o),
    .rd_a_addr_i (rd_a_addr_i),
    .rd_a_data_o (rd_a_data_o),
    .rd_b_addr_i (rd_b_addr_i),
    .rd_b_data_o (rd_b_data_o),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [WIDTH-1:0] pat(input int i);
    return WIDTH'((i * 37 + 5) & 8'hFF);
  endfunction

  // Called at a falling edge that opens an A slot; returns at the next such edge.
  task automatic cyc(input int a, input int b, input bit we, input int wa, input int wd,
                     input string tag_a, input string tag_b);
    logic [WIDTH-1:0] exp_a, exp_b;
    exp_a = model[a];
    exp_b = prev_we ? prev_b : model[b];
    rd_a_addr_i = AW'(a);
    rd_b_addr_i = AW'(b);
    wr_en_i     = we;
    wr_addr_i   = AW'(wa);
    wr_data_i   = WIDTH'(wd);
    @(negedge clk_i);
    chk(core_ce_o == 1'b1, "R1", int'(core_ce_o), 1);
    chk(rd_a_data_o == prev_a, "R4", int'(rd_a_data_o), int'(prev_a));
    chk(rd_b_data_o == prev_b, "R4", int'(rd_b_data_o), int'(prev_b));
    @(negedge clk_i);
    chk(core_ce_o == 1'b0, "R1", int'(core_ce_o), 0);
    chk(rd_a_data_o == exp_a, tag_a, int'(rd_a_data_o), int'(exp_a));
    chk(rd_b_data_o == exp_b, tag_b, int'(rd_b_data_o), int'(exp_b));
    if (we) model[wa] = WIDTH'(wd);
    prev_we = we;
    prev_a  = rd_a_data_o;
    prev_b  = rd_b_data_o;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    @(negedge clk_i);
    chk(rd_a_data_o == '0, "R9", int'(rd_a_data_o), 0);
    chk(rd_b_data_o == '0, "R9", int'(rd_b_data_o), 0);
    chk(core_ce_o == 1'b0, "R1", int'(core_ce_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    chk(core_ce_o == 1'b0, "R1", int'(core_ce_o), 0);
    @(negedge clk_i);
    chk(core_ce_o == 1'b1, "R1", int'(core_ce_o), 1);
    @(negedge clk_i);
    chk(core_ce_o == 1'b0, "R1", int'(core_ce_o), 0);

    // initial contents are zero
    cyc(0, 5, 1'b0, 0, 0, "R9", "R9");

    // fill: each cycle reads A at the address written one cycle earlier
    for (int i = 0; i < DEPTH; i++)
      cyc((i == 0) ? 0 : i - 1, i, 1'b1, i, int'(pat(i)), "R6", (i == 0) ? "R3" : "R7");
    cyc(DEPTH - 1, DEPTH - 1, 1'b0, 0, 0, "R6", "R7");

    // exhaustive read-pair sweep
    for (int a = 0; a < DEPTH; a++)
      for (int b = 0; b < DEPTH; b++)
        cyc(a, b, 1'b0, 0, 0, "R2", "R3");

    // disabled write with live address/data
    cyc(0, 1, 1'b0, 4, 'h5A, "R2", "R3");
    cyc(4, 4, 1'b0, 0, 0, "R8", "R8");

    // write seen by both ports two core cycles later
    cyc(2, 3, 1'b1, 9, 'hC3, "R2", "R3");
    cyc(7, 7, 1'b0, 0, 0, "R2", "R7");
    cyc(9, 9, 1'b0, 0, 0, "R5", "R5");

    // back-to-back writes to one address
    cyc(1, 2, 1'b1, 6, 'h11, "R2", "R3");
    cyc(6, 2, 1'b1, 6, 'h22, "R6", "R7");
    cyc(6, 6, 1'b0, 0, 0, "R6", "R7");
    cyc(6, 6, 1'b0, 0, 0, "R5", "R5");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule